// File: doc/BRIEF.md
# High/Low Time Clock Divider

This block divides an input clock by a programmable ratio. A 32-bit control word gives the number of input cycles the output spends high and the number it spends low. It also carries an odd-ratio marker, a pass-through flag and a hold flag. The output therefore need not have a 50 % duty cycle: any pair of phase lengths from 1 to 63 cycles can be produced. When the pass-through flag is set, the input clock is routed straight to the output.

The control word is a static input. It is sampled only at the close of a complete output period, so a change made partway through a period never cuts a phase short. A read-back path reports the ratio now in force and flags a word that was rejected. A word with a zero phase count and pass-through clear falls back to pass-through and raises the error flag.

The design is built around a three-state phase machine:
- `ST_BYPASS`: the output follows the input clock, and every input cycle is a period boundary.
- `ST_HIGH`: the output is held high.
- `ST_LOW`: the output is held low.

The machine has these transitions:
- *reload-to-high*: at a boundary, a valid dividing word is adopted.
- *reload-to-bypass*: at a boundary, a pass-through or rejected word is adopted.
- *hold*: at a boundary, the word carries the hold flag. The current configuration is kept, and the machine goes to `ST_HIGH` or stays in `ST_BYPASS` as that configuration requires.
- *high-expire*: the last high cycle ends and the machine moves to `ST_LOW`.
- A boundary is the last cycle of `ST_LOW`, or any cycle of `ST_BYPASS`.

Top module: `hl_clkdiv`

## Requirements
- R1: Field positions of `ctrl_word`:
  - low-phase count in bits 5:0 and high-phase count in bits 11:6;
  - pass-through flag in bit 13 and hold flag in bit 14;
  - the odd-ratio marker in bit 12 and the bits 31:15 have no effect on the output or on `ratio_out`.
- R2: In dividing mode, `clk_out` is high for exactly the high-phase count of input cycles, then low for exactly the low-phase count, and this repeats.
- R3: In dividing mode, `ratio_out` equals the high-phase count plus the low-phase count.
- R4: With bit 13 set, `clk_out` follows `clk_in` and `ratio_out` is 1, whatever the count fields hold.
- R5: A word with bit 13 clear and a zero high or low count behaves as in R4 and sets `cfg_err` to 1. `cfg_err` returns to 0 once a valid word is adopted.
- R6: A new word takes effect only after the last low cycle of the period in progress. That period completes with its old phase lengths.
- R7: A word with bit 14 set is never adopted. The phase lengths, `ratio_out` and `cfg_err` in force are kept.
- R8: While `rst_n` is low, `clk_out` is low. After release, the block is in pass-through with `ratio_out` = 1 and `cfg_err` = 0.
- R9: A ratio N ≥ 2 is programmed with high = floor(N/2), low = ceil(N/2), and bit 12 = N mod 2. N = 1 is programmed by setting bit 13. Words built this way give `ratio_out` = N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Divider control word, sampled at period boundaries |
| clk_out | output | 1 | Divided (or passed-through) clock |
| ratio_out | output | 7 | Divide ratio in force |
| cfg_err | output | 1 | Last adopted word was rejected (zero phase count) |

## Verification
The hardest situation to reach is a word change landing in the middle of a period. Only that case shows whether the old phases run to completion. The stimulus first settles on a 4/4 configuration, then waits for the sampled output to rise. It replaces the word on the first high cycle and counts the remaining high and low cycles before the new 1/1 pattern appears. A held word is exercised the same way: it is presented for far longer than one period, and the old phase lengths must still be measured afterwards.

// File: rtl/hl_clkdiv_pkg.sv
package hl_clkdiv_pkg;

    // Phase machine states; ST_HIGH is the only state with bit 0 set,
    // so the phase output decodes from a single flop.
    typedef enum logic [1:0] {
        ST_BYPASS = 2'b00,
        ST_HIGH   = 2'b01,
        ST_LOW    = 2'b10
    } phase_e;

endpackage

// File: rtl/hl_word_decode.sv
module hl_word_decode #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [WORD_W-1:0] ctrl_word,
    output logic [CNT_W-1:0]  w_hi,
    output logic [CNT_W-1:0]  w_lo,
    output logic              w_byp,
    output logic              w_err,
    output logic              w_hold
);
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = CNT_W;
    localparam int ODD_BIT = 2 * CNT_W;
    localparam int BYP_BIT = ODD_BIT + 1;
    localparam int HLD_BIT = ODD_BIT + 2;

    logic byp_flag;
    logic zero_cnt;

    always_comb begin
        w_lo     = ctrl_word[LO_LSB +: CNT_W];
        w_hi     = ctrl_word[HI_LSB +: CNT_W];
        byp_flag = ctrl_word[BYP_BIT];
        w_hold   = ctrl_word[HLD_BIT];
        // The odd-ratio marker at ODD_BIT is informational only.
        zero_cnt = (w_lo == '0) || (w_hi == '0);
        w_err    = !byp_flag && zero_cnt;
        w_byp    = byp_flag || zero_cnt;
    end

endmodule

// File: rtl/hl_phase_fsm.sv
module hl_phase_fsm
    import hl_clkdiv_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] w_hi,
    input  logic [CNT_W-1:0] w_lo,
    input  logic             w_byp,
    input  logic             w_err,
    input  logic             w_hold,
    output phase_e           state,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_hi,
    output logic [CNT_W-1:0] act_lo,
    output logic             act_byp,
    output logic             act_err,
    output logic             reload,
    output logic             phase_hi,
    output logic             byp_sel
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             load_cfg;
    logic             hi_last;
    logic             lo_last;

    always_comb begin
        hi_last  = (cnt == act_hi - ONE);
        lo_last  = (cnt == act_lo - ONE);
        reload   = (state == ST_BYPASS) || ((state == ST_LOW) && lo_last);
        load_cfg = reload && !w_hold;
    end

    // Next-state logic
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt + ONE;
        unique case (state)
            ST_BYPASS, ST_LOW: begin
                if (reload) begin
                    cnt_nxt = '0;
                    if (load_cfg) begin
                        nxt = w_byp ? ST_BYPASS : ST_HIGH;
                    end else begin
                        nxt = act_byp ? ST_BYPASS : ST_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                if (hi_last) begin
                    nxt     = ST_LOW;
                    cnt_nxt = '0;
                end
            end
            default: begin
                nxt     = ST_BYPASS;
                cnt_nxt = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BYPASS;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Configuration in force, replaced only at a boundary
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            act_hi  <= '0;
            act_lo  <= '0;
            act_byp <= 1'b1;
            act_err <= 1'b0;
        end else if (load_cfg) begin
            act_hi  <= w_hi;
            act_lo  <= w_lo;
            act_byp <= w_byp;
            act_err <= w_err;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        phase_hi = (state == ST_HIGH);
        byp_sel  = (state == ST_BYPASS);
    end

endmodule

// File: rtl/hl_clk_out.sv
module hl_clk_out (
    input  logic clk_in,
    input  logic rst_n,
    input  logic phase_hi,
    input  logic byp_sel,
    output logic clk_out
);
    logic out_en;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            out_en <= 1'b0;
        end else begin
            out_en <= 1'b1;
        end
    end

    // Selection changes only just after a rising input edge, while the
    // input is high, so neither path change produces a short pulse.
    always_comb begin
        clk_out = out_en && (byp_sel ? clk_in : phase_hi);
    end

endmodule

// File: rtl/hl_ratio_report.sv
module hl_ratio_report #(
    parameter int CNT_W = 6,
    localparam int RW   = CNT_W + 1
) (
    input  logic [CNT_W-1:0] act_hi,
    input  logic [CNT_W-1:0] act_lo,
    input  logic             act_byp,
    input  logic             act_err,
    output logic [RW-1:0]    ratio_out,
    output logic             cfg_err
);
    always_comb begin
        if (act_byp) begin
            ratio_out = RW'(1);
        end else begin
            ratio_out = {1'b0, act_hi} + {1'b0, act_lo};
        end
        cfg_err = act_err;
    end

endmodule

// File: rtl/hl_clkdiv.sv
module hl_clkdiv
    import hl_clkdiv_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6,
    localparam int RW    = CNT_W + 1
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ctrl_word,
    output logic              clk_out,
    output logic [RW-1:0]     ratio_out,
    output logic              cfg_err
);
    logic [CNT_W-1:0] w_hi;
    logic [CNT_W-1:0] w_lo;
    logic             w_byp;
    logic             w_err;
    logic             w_hold;
    phase_e           state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_hi;
    logic [CNT_W-1:0] act_lo;
    logic             act_byp;
    logic             act_err;
    logic             reload;
    logic             phase_hi;
    logic             byp_sel;

    hl_word_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_decode (
        .ctrl_word (ctrl_word),
        .w_hi      (w_hi),
        .w_lo      (w_lo),
        .w_byp     (w_byp),
        .w_err     (w_err),
        .w_hold    (w_hold)
    );

    hl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .w_hi     (w_hi),
        .w_lo     (w_lo),
        .w_byp    (w_byp),
        .w_err    (w_err),
        .w_hold   (w_hold),
        .state    (state),
        .cnt      (cnt),
        .act_hi   (act_hi),
        .act_lo   (act_lo),
        .act_byp  (act_byp),
        .act_err  (act_err),
        .reload   (reload),
        .phase_hi (phase_hi),
        .byp_sel  (byp_sel)
    );

    hl_clk_out u_out (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .phase_hi (phase_hi),
        .byp_sel  (byp_sel),
        .clk_out  (clk_out)
    );

    hl_ratio_report #(.CNT_W(CNT_W)) u_ratio (
        .act_hi    (act_hi),
        .act_lo    (act_lo),
        .act_byp   (act_byp),
        .act_err   (act_err),
        .ratio_out (ratio_out),
        .cfg_err   (cfg_err)
    );

endmodule

// File: rtl/hl_clkdiv_chk.sv
module hl_clkdiv_chk
    import hl_clkdiv_pkg::*;
#(
    parameter int CNT_W = 6,
    localparam int RW   = CNT_W + 1
) (
    input logic             clk_in,
    input logic             rst_n,
    input phase_e           state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_hi,
    input logic             act_byp,
    input logic             reload,
    input logic             w_hold,
    input logic             w_byp,
    input logic [RW-1:0]    ratio_out,
    input logic             cfg_err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2: the high phase runs until its count is used up
    p_high_run_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state == ST_HIGH && cnt != act_hi - ONE) |=> state == ST_HIGH);

    // R2: the last high cycle is followed by the low phase
    p_high_exit_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state == ST_HIGH && cnt == act_hi - ONE) |=> state == ST_LOW);

    // R2: the low phase is left only at a boundary
    p_low_run_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state == ST_LOW && !reload) |=> state == ST_LOW);

    // R4: an adopted pass-through word reports ratio 1
    p_bypass_ratio_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        (reload && !w_hold && w_byp) |=> (ratio_out == RW'(1) && state == ST_BYPASS));

    // R5: a rejected word leaves the block in pass-through
    p_err_bypass_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        cfg_err |-> (ratio_out == RW'(1) && state == ST_BYPASS));

    // R6: the reported ratio moves only after a boundary
    p_reload_only_end_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$stable(ratio_out) |-> $past(reload));

    // R7: a held word keeps ratio and error flag
    p_hold_keeps_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (reload && w_hold) |=> ($stable(ratio_out) && $stable(cfg_err)));

    // R4: the pass-through configuration and the machine state agree
    p_bypass_state_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        act_byp |-> state == ST_BYPASS);

endmodule

bind hl_clkdiv hl_clkdiv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .state     (state),
    .cnt       (cnt),
    .act_hi    (act_hi),
    .act_byp   (act_byp),
    .reload    (reload),
    .w_hold    (w_hold),
    .w_byp     (w_byp),
    .ratio_out (ratio_out),
    .cfg_err   (cfg_err)
);

// File: tb/test_hl_clkdiv.sv
`timescale 1ns/1ps
module test_hl_clkdiv;

    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b1;
    logic [31:0] ctrl_word = 32'h0000_2000;
    logic        clk_out;
    logic [6:0]  ratio_out;
    logic        cfg_err;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #10 clk_in = ~clk_in;  // 50 MHz

    hl_clkdiv i_hl_clkdiv (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .clk_out   (clk_out),
        .ratio_out (ratio_out),
        .cfg_err   (cfg_err)
    );

    typedef struct packed {
        logic [31:0] word;
        logic [7:0]  hi;
        logic [7:0]  lo;
    } vec_t;

    // Word, expected high cycles, expected low cycles
    localparam vec_t VECS [7] = '{
        '{32'h0000_0041, 8'd1,  8'd1},   // R2 ratio 2
        '{32'h0000_1042, 8'd1,  8'd2},   // R2 ratio 3
        '{32'h0000_0104, 8'd4,  8'd4},   // R2 ratio 8
        '{32'h0000_1597, 8'd22, 8'd23},  // R2 ratio 45
        '{32'hFFFF_80C1, 8'd3,  8'd1},   // R1 reserved bits set
        '{32'h0000_1082, 8'd2,  8'd2},   // R1 marker bit mismatched
        '{32'h0000_0FFF, 8'd63, 8'd63}   // R2 largest counts
    };

    always @(posedge clk_in) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(output logic s);
        @(posedge clk_in);
        #5;
        s = clk_out;
    endtask

    task automatic wait_cycles(input int n);
        logic s;
        for (int i = 0; i < n; i++) tick(s);
    endtask

    // Synchronise on a sampled rise, then count the high and low run
    task automatic measure(output int hi_n, output int lo_n);
        logic s;
        logic prev;
        int   guard;
        hi_n  = 0;
        lo_n  = 0;
        guard = 0;
        tick(prev);
        tick(s);
        while (!(prev == 1'b0 && s == 1'b1) && guard < 300) begin
            prev = s;
            tick(s);
            guard++;
        end
        while (s == 1'b1 && guard < 600) begin hi_n++; tick(s); guard++; end
        while (s == 1'b0 && guard < 900) begin lo_n++; tick(s); guard++; end
    endtask

    // Pass-through: high a quarter period after rise, low after fall
    task automatic check_follow(input string req);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_in); #5;
            check(clk_out == 1'b1, req, int'(clk_out), 1);
            @(negedge clk_in); #5;
            check(clk_out == 1'b0, req, int'(clk_out), 0);
        end
    endtask

    function automatic logic [31:0] enc(input int n);
        logic [31:0] w;
        int h;
        int l;
        w = '0;
        if (n == 1) begin
            w[13] = 1'b1;
        end else begin
            h = n / 2;
            l = n - h;
            w[5:0]  = l[5:0];
            w[11:6] = h[5:0];
            w[12]   = (n % 2) == 1;
        end
        return w;
    endfunction

    initial begin
        int hi_n;
        int lo_n;
        logic s;

        // R8: reset holds the output low and loads pass-through
        #1 rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk_in); #5;
            check(clk_out == 1'b0, "R8 output low in reset", int'(clk_out), 0);
        end
        rst_n = 1'b1;
        wait_cycles(3);
        check(ratio_out == 7'd1, "R8 ratio after reset", int'(ratio_out), 1);
        check(cfg_err == 1'b0, "R8 error after reset", int'(cfg_err), 0);
        check_follow("R8 pass-through after reset");

        // R2/R3/R1: table of dividing words
        for (int v = 0; v < 7; v++) begin
            ctrl_word = VECS[v].word;
            wait_cycles(280);
            measure(hi_n, lo_n);
            check(hi_n == int'(VECS[v].hi), "R2 high phase", hi_n, int'(VECS[v].hi));
            check(lo_n == int'(VECS[v].lo), "R2 low phase", lo_n, int'(VECS[v].lo));
            check(int'(ratio_out) == int'(VECS[v].hi) + int'(VECS[v].lo), "R3 ratio",
                  int'(ratio_out), int'(VECS[v].hi) + int'(VECS[v].lo));
            check(cfg_err == 1'b0, "R1 no error", int'(cfg_err), 0);
        end

        // R4: pass-through flag overrides nonzero counts
        ctrl_word = 32'h0000_2104;
        wait_cycles(140);
        check(ratio_out == 7'd1, "R4 ratio in pass-through", int'(ratio_out), 1);
        check(cfg_err == 1'b0, "R4 no error", int'(cfg_err), 0);
        check_follow("R4 output follows input");

        // R5: zero high count with pass-through clear
        ctrl_word = 32'h0000_0005;
        wait_cycles(10);
        check(cfg_err == 1'b1, "R5 error raised", int'(cfg_err), 1);
        check(ratio_out == 7'd1, "R5 ratio falls back", int'(ratio_out), 1);
        check_follow("R5 output follows input");
        ctrl_word = 32'h0000_0140;  // zero low count
        wait_cycles(10);
        check(cfg_err == 1'b1, "R5 zero low raises error", int'(cfg_err), 1);
        ctrl_word = enc(7);
        wait_cycles(40);
        check(cfg_err == 1'b0, "R5 error clears", int'(cfg_err), 0);

        // R9: encoding convention
        check(ratio_out == 7'd7, "R9 ratio 7", int'(ratio_out), 7);
        measure(hi_n, lo_n);
        check(hi_n == 3 && lo_n == 4, "R9 split of 7", hi_n * 10 + lo_n, 34);
        ctrl_word = enc(1);
        wait_cycles(40);
        check(ratio_out == 7'd1, "R9 ratio 1 via pass-through", int'(ratio_out), 1);

        // R7: held word is not adopted
        ctrl_word = enc(6);
        wait_cycles(40);
        ctrl_word = 32'h0000_4082;
        wait_cycles(200);
        measure(hi_n, lo_n);
        check(hi_n == 3 && lo_n == 3, "R7 phases kept", hi_n * 10 + lo_n, 33);
        check(ratio_out == 7'd6, "R7 ratio kept", int'(ratio_out), 6);

        // R6: change in the middle of a period
        ctrl_word = 32'h0000_0104;
        wait_cycles(60);
        begin
            logic prev;
            int   guard;
            int   h2;
            int   l2;
            guard = 0;
            tick(prev);
            tick(s);
            while (!(prev == 1'b0 && s == 1'b1) && guard < 100) begin
                prev = s;
                tick(s);
                guard++;
            end
            ctrl_word = 32'h0000_0041;
            hi_n = 0; lo_n = 0; h2 = 0; l2 = 0;
            while (s == 1'b1 && guard < 200) begin hi_n++; tick(s); guard++; end
            while (s == 1'b0 && guard < 300) begin lo_n++; tick(s); guard++; end
            while (s == 1'b1 && guard < 400) begin h2++; tick(s); guard++; end
            while (s == 1'b0 && guard < 500) begin l2++; tick(s); guard++; end
            check(hi_n == 4, "R6 old high completes", hi_n, 4);
            check(lo_n == 4, "R6 old low completes", lo_n, 4);
            check(h2 == 1 && l2 == 1, "R6 new phases after boundary", h2 * 10 + l2, 11);
        end
        check(ratio_out == 7'd2, "R6 ratio updated", int'(ratio_out), 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule